// File: doc/BRIEF.md
# Cathode Segment Pattern Finder

The block looks for short track segments in a six-layer strip chamber. Each crossing it receives one comparator bit per half-strip per layer. It then runs two searches side by side. The first works at half-strip resolution. The second first folds each group of four neighbouring half-strips into a single di-strip bit and then searches at that coarser resolution. Both searches try seven numbered bend shapes at every key position and keep the shape that covers the most layers.

A small state machine decides when to trigger. It has three states: `ST_IDLE`, `ST_ARMED` and `ST_DEAD`. From `ST_IDLE`, the `pretrig_seen` transition fires when any candidate covers enough layers. In `ST_ARMED` there are two exits. The `confirm_ok` transition emits up to two segments and enters `ST_DEAD`. The `confirm_miss` transition returns to `ST_IDLE` with no output. The `dead_done` transition leaves `ST_DEAD` after a fixed number of crossings. Each reported segment carries:
- a two-bit quality,
- the shape number,
- the key position,
- a flag that tells half-strip results from di-strip results.

Top module: `cstrip_seg_finder`

## Requirements
- R1: While `rst_n` is low, both segment valid outputs are 0, and the state machine starts in `ST_IDLE`.
- R2: Di-strip bit j of a layer is the OR of half-strip bits 4j to 4j+3 of that layer. A di-strip segment reports `segN_ds`=1, and its key is j in di-strip units. A half-strip segment reports `segN_ds`=0, and its key is in half-strip units. Input bit `l*N_HS+k` is half-strip k of layer l.
- R3: A layer is counted for shape p at key k if it has a hit at any of the offsets from k that the shape allows on that layer, listed for layers 0 to 5:
  - Shape 4 allows offset 0 on every layer.
  - Shape 1 allows {-1},{-1},{-1,0},{0},{0,+1},{+1}.
  - Shape 2 allows {0},{0},{0},{0},{+1},{+1}.
  - Shape 3 allows {-1},{-1},{-1,0},{0},{0},{0}.
  - Shapes 7, 6 and 5 are shapes 1, 2 and 3 with every offset negated.
- R4: The `pretrig_seen` transition fires in `ST_IDLE` when the best layer count is at least PRE_LAY (default 2). In `ST_ARMED`, the inputs of that next crossing are searched. A best count of at least CONF_LAY (default 4) takes `confirm_ok`. A lower count takes `confirm_miss` and emits nothing.
- R5: Quality equals the segment's layer count minus 3.
- R6: The first segment is the best candidate overall. Candidates are ranked by:
  - more layers first,
  - then half-strip ahead of di-strip,
  - then straighter shape (4, then 3 or 5, then 2 or 6, then 1 or 7; shape 3 beats 5, 2 beats 6, 1 beats 7 at one key),
  - then the lower key.
- R7: The second segment is the best remaining candidate with at least CONF_LAY layers. Candidates that are too close to the first segment are excluded:
  - For the same type, a key within 1 of the first key is too close.
  - For mixed types, the half-strip key is divided by 4 first, and a result within 1 of the other key is too close.
- R8: After `confirm_ok`, the finder stays in `ST_DEAD` for DEAD_BX crossings (default 9). With hits held steady, the next segment appears DEAD_BX+2 crossings after the previous one.
- R9: The valid outputs are registered and pulse for exactly one crossing, one crossing after the confirming inputs are present. `seg1_vld` is only ever high together with `seg0_vld`.
- R10: Positions beyond either end of a layer read as no hit, and keys 0 and N_HS-1 produce segments like any other key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | crossing clock |
| rst_n | input | 1 | asynchronous active-low reset |
| hs_i | input | 6*N_HS | half-strip comparator bits, layer-major |
| seg0_vld | output | 1 | first segment present |
| seg0_qual | output | 2 | first segment quality |
| seg0_pat | output | 3 | first segment shape number |
| seg0_key | output | clog2(N_HS) | first segment key position |
| seg0_ds | output | 1 | first segment is di-strip |
| seg1_vld | output | 1 | second segment present |
| seg1_qual | output | 2 | second segment quality |
| seg1_pat | output | 3 | second segment shape number |
| seg1_key | output | clog2(N_HS) | second segment key position |
| seg1_ds | output | 1 | second segment is di-strip |

## Verification
The hardest situation to reach is a second segment that must be rejected only because it sits next to the first. A straight track and a second track one half-strip away produce a five-layer bent candidate at the adjacent key. That candidate would win the second slot if the exclusion rule were wrong. The stimulus places two tracks exactly one and exactly two half-strips apart, and places a di-strip track far from a half-strip track. Together these cases show the exclusion boundary and the mixed-type distance rule from the outputs alone.

// File: rtl/csf_pkg.sv
package csf_pkg;

    localparam int NLAY = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DEAD  = 2'd2
    } fsm_t;

    typedef struct packed {
        logic [2:0] lay;
        logic [2:0] pat;
    } pick_t;

    // bit 0: offset -1, bit 1: offset 0, bit 2: offset +1
    function automatic logic [2:0] pat_cols(input int p, input int l);
        logic [2:0] m;
        int q;
        q = (p > 4) ? 8 - p : p;
        case (q)
            1: begin
                case (l)
                    0, 1:    m = 3'b001;
                    2:       m = 3'b011;
                    3:       m = 3'b010;
                    4:       m = 3'b110;
                    default: m = 3'b100;
                endcase
            end
            2: m = (l < 4) ? 3'b010 : 3'b100;
            3: begin
                case (l)
                    0, 1:    m = 3'b001;
                    2:       m = 3'b011;
                    default: m = 3'b010;
                endcase
            end
            default: m = 3'b010;
        endcase
        if (p > 4) m = {m[0], m[1], m[2]};
        return m;
    endfunction

    function automatic logic [5:0] rank_score(input pick_t pk, input logic is_ds);
        int bend;
        if (pk.lay == 3'd0) return 6'd0;
        bend = (pk.pat > 3'd4) ? int'(pk.pat) - 4 : 4 - int'(pk.pat);
        return {pk.lay, ~is_ds, 2'(3 - bend)};
    endfunction

    function automatic logic too_close(input int ka, input logic da,
                                       input int kb, input logic db);
        int a;
        int b;
        int diff;
        a = ka;
        b = kb;
        if (da != db) begin
            if (!da) a = ka / 4;
            if (!db) b = kb / 4;
        end
        diff = (a > b) ? a - b : b - a;
        return diff < 2;
    endfunction

endpackage

// File: rtl/csf_ds_merge.sv
module csf_ds_merge import csf_pkg::*; #(
    parameter int N_HS = 32,
    localparam int N_DS = N_HS / 4
) (
    input  logic [NLAY*N_HS-1:0] hs_i,
    output logic [NLAY*N_DS-1:0] ds_o
);
    for (genvar l = 0; l < NLAY; l++) begin : g_lay
        for (genvar j = 0; j < N_DS; j++) begin : g_ds
            assign ds_o[l*N_DS + j] = |hs_i[l*N_HS + 4*j +: 4];
        end
    end
endmodule

// File: rtl/csf_pat_scan.sv
module csf_pat_scan import csf_pkg::*; #(
    parameter int W = 32,
    localparam int WP = W + 2
) (
    input  logic [NLAY*W-1:0] bits_i,
    output pick_t             pick_o [W]
);
    logic [NLAY*WP-1:0] pad;

    for (genvar l = 0; l < NLAY; l++) begin : g_pad
        assign pad[l*WP +: WP] = {1'b0, bits_i[l*W +: W], 1'b0};
    end

    for (genvar k = 0; k < W; k++) begin : g_key
        always_comb begin
            pick_t      best;
            int         p;
            logic [2:0] cnt;
            logic [2:0] m;
            logic       hit;
            best = '0;
            // straightest shapes are visited first; only a strictly larger count replaces
            for (int d = 0; d < 4; d++) begin
                for (int s = 0; s < 2; s++) begin
                    p   = (s == 0) ? 4 - d : 4 + d;
                    cnt = 3'd0;
                    if (!(d == 0 && s == 1)) begin
                        for (int l = 0; l < NLAY; l++) begin
                            m   = pat_cols(p, l);
                            hit = 1'b0;
                            for (int c = 0; c < 3; c++) begin
                                hit = hit | (m[c] & pad[l*WP + k + c]);
                            end
                            cnt = cnt + {2'b00, hit};
                        end
                        if (cnt > best.lay) begin
                            best.lay = cnt;
                            best.pat = 3'(p);
                        end
                    end
                end
            end
            pick_o[k] = best;
        end
    end
endmodule

// File: rtl/csf_seg_select.sv
module csf_seg_select import csf_pkg::*; #(
    parameter int N_HS     = 32,
    parameter int N_DS     = 8,
    parameter int KW       = 5,
    parameter int CONF_LAY = 4
) (
    input  pick_t          hs_i [N_HS],
    input  pick_t          ds_i [N_DS],
    output pick_t          fst_o,
    output logic [KW-1:0]  fst_key_o,
    output logic           fst_ds_o,
    output logic           fst_vld_o,
    output pick_t          snd_o,
    output logic [KW-1:0]  snd_key_o,
    output logic           snd_ds_o,
    output logic           snd_vld_o
);
    always_comb begin
        logic [5:0] bsc;
        logic [5:0] sc;
        bsc       = 6'd0;
        fst_o     = '0;
        fst_key_o = '0;
        fst_ds_o  = 1'b0;
        for (int k = 0; k < N_HS; k++) begin
            sc = rank_score(hs_i[k], 1'b0);
            if (sc > bsc) begin
                bsc = sc; fst_o = hs_i[k]; fst_key_o = KW'(k); fst_ds_o = 1'b0;
            end
        end
        for (int j = 0; j < N_DS; j++) begin
            sc = rank_score(ds_i[j], 1'b1);
            if (sc > bsc) begin
                bsc = sc; fst_o = ds_i[j]; fst_key_o = KW'(j); fst_ds_o = 1'b1;
            end
        end
        fst_vld_o = (int'(fst_o.lay) >= CONF_LAY);
    end

    always_comb begin
        logic [5:0] bsc;
        logic [5:0] sc;
        bsc       = 6'd0;
        snd_o     = '0;
        snd_key_o = '0;
        snd_ds_o  = 1'b0;
        for (int k = 0; k < N_HS; k++) begin
            sc = rank_score(hs_i[k], 1'b0);
            if (sc > bsc && !too_close(k, 1'b0, int'(fst_key_o), fst_ds_o)) begin
                bsc = sc; snd_o = hs_i[k]; snd_key_o = KW'(k); snd_ds_o = 1'b0;
            end
        end
        for (int j = 0; j < N_DS; j++) begin
            sc = rank_score(ds_i[j], 1'b1);
            if (sc > bsc && !too_close(j, 1'b1, int'(fst_key_o), fst_ds_o)) begin
                bsc = sc; snd_o = ds_i[j]; snd_key_o = KW'(j); snd_ds_o = 1'b1;
            end
        end
        snd_vld_o = fst_vld_o && (int'(snd_o.lay) >= CONF_LAY);
    end
endmodule

// File: rtl/cstrip_seg_finder.sv
module cstrip_seg_finder import csf_pkg::*; #(
    parameter int N_HS     = 32,
    parameter int PRE_LAY  = 2,
    parameter int CONF_LAY = 4,
    parameter int DEAD_BX  = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NLAY*N_HS-1:0]      hs_i,
    output logic                      seg0_vld,
    output logic [1:0]                seg0_qual,
    output logic [2:0]                seg0_pat,
    output logic [$clog2(N_HS)-1:0]   seg0_key,
    output logic                      seg0_ds,
    output logic                      seg1_vld,
    output logic [1:0]                seg1_qual,
    output logic [2:0]                seg1_pat,
    output logic [$clog2(N_HS)-1:0]   seg1_key,
    output logic                      seg1_ds
);
    localparam int N_DS = N_HS / 4;
    localparam int KW   = $clog2(N_HS);
    localparam int DW   = $clog2(DEAD_BX + 1);

    logic [NLAY*N_DS-1:0] ds_bits;
    pick_t                hs_pick [N_HS];
    pick_t                ds_pick [N_DS];
    pick_t                fst, snd;
    logic [KW-1:0]        fst_key, snd_key;
    logic                 fst_ds, snd_ds, fst_vld, snd_vld;
    logic                 pre_hit;
    fsm_t                 st, nxt;
    logic [DW-1:0]        dcnt;

    csf_ds_merge #(.N_HS(N_HS)) u_merge (
        .hs_i (hs_i),
        .ds_o (ds_bits)
    );

    csf_pat_scan #(.W(N_HS)) u_scan_hs (
        .bits_i (hs_i),
        .pick_o (hs_pick)
    );

    csf_pat_scan #(.W(N_DS)) u_scan_ds (
        .bits_i (ds_bits),
        .pick_o (ds_pick)
    );

    csf_seg_select #(
        .N_HS(N_HS), .N_DS(N_DS), .KW(KW), .CONF_LAY(CONF_LAY)
    ) u_sel (
        .hs_i      (hs_pick),
        .ds_i      (ds_pick),
        .fst_o     (fst),
        .fst_key_o (fst_key),
        .fst_ds_o  (fst_ds),
        .fst_vld_o (fst_vld),
        .snd_o     (snd),
        .snd_key_o (snd_key),
        .snd_ds_o  (snd_ds),
        .snd_vld_o (snd_vld)
    );

    assign pre_hit = (int'(fst.lay) >= PRE_LAY);

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (pre_hit) nxt = ST_ARMED;
            ST_ARMED: nxt = fst_vld ? ST_DEAD : ST_IDLE;
            ST_DEAD:  if (dcnt == '0) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register with the dead-time counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            dcnt <= '0;
        end else begin
            st <= nxt;
            if (st == ST_ARMED && fst_vld) dcnt <= DW'(DEAD_BX - 1);
            else if (st == ST_DEAD && dcnt != '0) dcnt <= dcnt - 1'b1;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg0_vld  <= 1'b0; seg0_qual <= '0; seg0_pat <= '0; seg0_key <= '0; seg0_ds <= 1'b0;
            seg1_vld  <= 1'b0; seg1_qual <= '0; seg1_pat <= '0; seg1_key <= '0; seg1_ds <= 1'b0;
        end else begin
            seg0_vld <= (st == ST_ARMED) && fst_vld;
            seg1_vld <= (st == ST_ARMED) && snd_vld;
            if (st == ST_ARMED) begin
                seg0_qual <= 2'(fst.lay - 3'd3);
                seg0_pat  <= fst.pat;
                seg0_key  <= fst_key;
                seg0_ds   <= fst_ds;
                seg1_qual <= 2'(snd.lay - 3'd3);
                seg1_pat  <= snd.pat;
                seg1_key  <= snd_key;
                seg1_ds   <= snd_ds;
            end
        end
    end
endmodule

// File: rtl/csf_chk.sv
module csf_chk import csf_pkg::*; #(
    parameter int KW       = 5,
    parameter int DEAD_BX  = 9,
    parameter int CONF_LAY = 4,
    localparam int DW = $clog2(DEAD_BX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input fsm_t          st,
    input logic          seg0_vld,
    input logic [1:0]    seg0_qual,
    input logic [KW-1:0] seg0_key,
    input logic          seg0_ds,
    input logic          seg1_vld,
    input logic [1:0]    seg1_qual,
    input logic [KW-1:0] seg1_key,
    input logic          seg1_ds
);
    logic [DW-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          gap <= '0;
        else if (seg0_vld)   gap <= DW'(DEAD_BX);
        else if (gap != '0)  gap <= gap - 1'b1;
    end

    // R9
    second_with_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg1_vld |-> seg0_vld);

    // R4
    emit_after_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg0_vld |-> $past(st == ST_ARMED));

    // R5
    qual_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg0_vld |-> (int'(seg0_qual) + 3 >= CONF_LAY));

    // R7
    second_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg1_vld && seg1_ds == seg0_ds) |->
        ((int'(seg1_key) - int'(seg0_key) >= 2) || (int'(seg0_key) - int'(seg1_key) >= 2)));

    // R6
    first_ranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg1_vld |-> ({seg0_qual, ~seg0_ds} >= {seg1_qual, ~seg1_ds}));

    // R8
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap != '0) |-> !seg0_vld);
endmodule

bind cstrip_seg_finder csf_chk #(
    .KW(KW), .DEAD_BX(DEAD_BX), .CONF_LAY(CONF_LAY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .seg0_vld  (seg0_vld),
    .seg0_qual (seg0_qual),
    .seg0_key  (seg0_key),
    .seg0_ds   (seg0_ds),
    .seg1_vld  (seg1_vld),
    .seg1_qual (seg1_qual),
    .seg1_key  (seg1_key),
    .seg1_ds   (seg1_ds)
);

// File: tb/cstrip_seg_finder_bench.sv
module cstrip_seg_finder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_HS = 32;
    localparam int NL = 6;
    localparam int DEAD_BX = 9;
    localparam int NV = 13;

    typedef struct packed {
        logic [0:5][7:0] ha;
        logic [0:5][7:0] hb;
        logic       e0v;
        logic [1:0] e0q;
        logic [2:0] e0p;
        logic [4:0] e0k;
        logic       e0d;
        logic       e1v;
        logic [1:0] e1q;
        logic [2:0] e1p;
        logic [4:0] e1k;
        logic       e1d;
    } vec_t;

    localparam logic [0:5][7:0] NO = {6{8'hFF}};

    localparam vec_t TBL [NV] = '{
        // R4/R6 straight six layers at 10
        '{ {6{8'd10}}, NO, 1'b1, 2'd3, 3'd4, 5'd10, 1'b0, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0 },
        // R5 five layers at 20
        '{ {8'd20,8'd20,8'd20,8'd20,8'd20,8'hFF}, NO, 1'b1, 2'd2, 3'd4, 5'd20, 1'b0, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0 },
        // R4 three layers: armed but not confirmed
        '{ {8'd5,8'd5,8'd5,8'hFF,8'hFF,8'hFF}, NO, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0 },
        // R4 single layer: never armed
        '{ {8'd7,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF}, NO, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0 },
        // R7 two separated half-strip tracks
        '{ {6{8'd4}}, {8'd24,8'd24,8'd24,8'd24,8'hFF,8'hFF}, 1'b1, 2'd3, 3'd4, 5'd4, 1'b0, 1'b1, 2'd1, 3'd4, 5'd24, 1'b0 },
        // R3 shape 1 bend; di-strip twin excluded
        '{ {8'd15,8'd15,8'd15,8'd16,8'd17,8'd17}, NO, 1'b1, 2'd3, 3'd1, 5'd16, 1'b0, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0 },
        // R2 scattered hits inside one di-strip
        '{ {8'd8,8'd9,8'd10,8'd11,8'd8,8'd9}, NO, 1'b1, 2'd3, 3'd4, 5'd2, 1'b1, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0 },
        // R3 shape 2 bend
        '{ {8'd16,8'd16,8'd16,8'd16,8'd17,8'd17}, NO, 1'b1, 2'd3, 3'd2, 5'd16, 1'b0, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0 },
        // R7 neighbour one key away is excluded
        '{ {6{8'd10}}, {8'd11,8'd11,8'd11,8'd11,8'd11,8'hFF}, 1'b1, 2'd3, 3'd4, 5'd10, 1'b0, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0 },
        // R7 two keys away is allowed
        '{ {6{8'd10}}, {8'd12,8'd12,8'd12,8'd12,8'hFF,8'hFF}, 1'b1, 2'd3, 3'd4, 5'd10, 1'b0, 1'b1, 2'd1, 3'd4, 5'd12, 1'b0 },
        // R10 low edge
        '{ {6{8'd0}}, NO, 1'b1, 2'd3, 3'd4, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0 },
        // R10 high edge
        '{ {6{8'd31}}, NO, 1'b1, 2'd3, 3'd4, 5'd31, 1'b0, 1'b0, 2'd0, 3'd0, 5'd0, 1'b0 },
        // R6/R2 half-strip ahead of di-strip at equal layers, di-strip second
        '{ {6{8'd4}}, {8'd20,8'd21,8'd22,8'd23,8'd20,8'd21}, 1'b1, 2'd3, 3'd4, 5'd4, 1'b0, 1'b1, 2'd3, 3'd4, 5'd5, 1'b1 }
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NL*N_HS-1:0] hs = '0;
    logic              seg0_vld, seg0_ds, seg1_vld, seg1_ds;
    logic [1:0]        seg0_qual, seg1_qual;
    logic [2:0]        seg0_pat, seg1_pat;
    logic [4:0]        seg0_key, seg1_key;
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cstrip_seg_finder #(.N_HS(N_HS), .DEAD_BX(DEAD_BX)) u_cstrip_seg_finder (
        .clk(clk), .rst_n(rst_n), .hs_i(hs),
        .seg0_vld(seg0_vld), .seg0_qual(seg0_qual), .seg0_pat(seg0_pat),
        .seg0_key(seg0_key), .seg0_ds(seg0_ds),
        .seg1_vld(seg1_vld), .seg1_qual(seg1_qual), .seg1_pat(seg1_pat),
        .seg1_key(seg1_key), .seg1_ds(seg1_ds)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [NL*N_HS-1:0] build(input logic [0:5][7:0] a,
                                                 input logic [0:5][7:0] b);
        logic [NL*N_HS-1:0] v;
        v = '0;
        for (int l = 0; l < NL; l++) begin
            if (a[l] != 8'hFF) v[l*N_HS + int'(a[l])] = 1'b1;
            if (b[l] != 8'hFF) v[l*N_HS + int'(b[l])] = 1'b1;
        end
        return v;
    endfunction

    task automatic settle();
        hs = '0;
        repeat (DEAD_BX + 4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 seg0_vld in reset", int'(seg0_vld), 0);
        check("R1 seg1_vld in reset", int'(seg1_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            hs = build(TBL[i].ha, TBL[i].hb);
            repeat (2) @(negedge clk);
            check($sformatf("R4/R9 v%0d seg0_vld", i), int'(seg0_vld), int'(TBL[i].e0v));
            if (TBL[i].e0v) begin
                check($sformatf("R5 v%0d seg0_qual", i), int'(seg0_qual), int'(TBL[i].e0q));
                check($sformatf("R3/R6 v%0d seg0_pat", i), int'(seg0_pat), int'(TBL[i].e0p));
                check($sformatf("R6/R10 v%0d seg0_key", i), int'(seg0_key), int'(TBL[i].e0k));
                check($sformatf("R2 v%0d seg0_ds", i), int'(seg0_ds), int'(TBL[i].e0d));
            end
            check($sformatf("R7 v%0d seg1_vld", i), int'(seg1_vld), int'(TBL[i].e1v));
            if (TBL[i].e1v) begin
                check($sformatf("R5 v%0d seg1_qual", i), int'(seg1_qual), int'(TBL[i].e1q));
                check($sformatf("R7 v%0d seg1_pat", i), int'(seg1_pat), int'(TBL[i].e1p));
                check($sformatf("R7 v%0d seg1_key", i), int'(seg1_key), int'(TBL[i].e1k));
                check($sformatf("R2 v%0d seg1_ds", i), int'(seg1_ds), int'(TBL[i].e1d));
            end
            settle();
        end

        // R4 confirm uses the crossing after the pre-trigger
        hs = build({8'd10,8'd10,8'hFF,8'hFF,8'hFF,8'hFF}, NO);
        @(negedge clk);
        hs = build({6{8'd10}}, NO);
        @(negedge clk);
        check("R4 late confirm seg0_vld", int'(seg0_vld), 1);
        check("R4 late confirm seg0_qual", int'(seg0_qual), 3);
        settle();

        // R8 dead time with hits held; R9 single-crossing pulse
        begin
            int n;
            hs = build({6{8'd10}}, NO);
            repeat (2) @(negedge clk);
            check("R8 first pulse", int'(seg0_vld), 1);
            @(negedge clk);
            check("R9 pulse drops", int'(seg0_vld), 0);
            n = 1;
            while (!seg0_vld && n < 50) begin
                @(negedge clk);
                n++;
            end
            check("R8 crossings between pulses", n, DEAD_BX + 2);
            settle();
        end

        // R1 reset while armed suppresses output
        hs = build({6{8'd10}}, NO);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset while armed", int'(seg0_vld), 0);
        rst_n = 1'b1;
        settle();

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule